// File: doc/BRIEF.md
# Stereo Echo Delay with FIR Filter and Feedback

This block runs once per audio sample. When the sample strobe arrives it fetches one stereo frame from a circular delay area held in an external byte-wide memory. It passes each channel of that frame through an 8-tap FIR filter. It then builds a new frame from the voice echo-send sums plus a scaled copy of the filtered signal, and stores that frame back to the slot it has just read. The same slot comes round again one delay length later, and that is what produces the repeating, decaying echo.

The block also forms the final stereo output for the sample. For each channel it adds the main voice mix, scaled by a master volume, to the filtered echo, scaled by an echo volume, and saturates the result to 16 bits.

Two flags control the sample. One stops the write-back, which freezes the contents of the delay area. The other silences the final output. The delay area sits at a 256-byte page selected by a register. Its length is a multiple of 2048 bytes, and the delay code that sets it is re-read only when the slot position wraps back to zero.

Top module: `echo_fir_unit`

## Requirements
- R1: Each sample touches the 4-byte frame at address (echo_page*256 + offset) mod 65536, in this byte order: left low, left high, right low, right high. The samples are signed little-endian. All four reads are issued one per cycle before any write, and `mem_rdata` is taken one cycle after its `mem_rd` cycle. `mem_rd` and `mem_wr` are never both high.
- R2: The offset is 0 after reset and advances by 4 each sample. It returns to 0 when it reaches the delay length. The length is delay_code*2048 bytes, and it is reloaded from `delay_code` only on a sample that starts at offset 0. A latched length of 0 makes every sample use the same frame.
- R3: Let x[n] be the frame value just read and x[n-k] the value read k samples earlier. Each channel's filter result is c7*x[n] + c6*x[n-1] + c5*x[n-2] + ... + c0*x[n-7]. Coefficient ci is the signed byte at `coef_bus[8i+7:8i]`. Reset clears the history to zero.
- R4: The written-back value per channel is sat16((send >>> 7) + ((fir * fb_gain) >>> 14)). Both shifts are arithmetic, and `fb_gain` is a signed byte.
- R5: While `wr_inhibit` is 1, the sample issues no write and the frame in memory keeps its old bytes.
- R6: The output per channel is sat16((main * mvol + fir * evol) >>> 14). All volumes are signed bytes.
- R7: While `mute` is 1, both outputs become 0. The write-back is not affected.
- R8: sat16 turns any value above 32767 into 0x7FFF and any value below -32768 into 0x8000. Values in range pass through unchanged.
- R9: `out_valid` pulses for exactly one cycle per accepted strobe, when new outputs appear. Outputs hold between pulses and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | Starts one sample; accepted when idle |
| echo_page | input | 8 | Page of the delay area |
| delay_code | input | 4 | Delay length in 2048-byte units |
| coef_bus | input | 64 | Eight signed 8-bit filter coefficients |
| fb_gain | input | 8 | Signed feedback gain |
| mvol_l | input | 8 | Signed master volume, left |
| mvol_r | input | 8 | Signed master volume, right |
| evol_l | input | 8 | Signed echo volume, left |
| evol_r | input | 8 | Signed echo volume, right |
| wr_inhibit | input | 1 | Blocks the write-back |
| mute | input | 1 | Forces outputs to zero |
| send_l | input | 32 | Signed voice echo-send sum, left |
| send_r | input | 32 | Signed voice echo-send sum, right |
| main_l | input | 32 | Signed main voice sum, left |
| main_r | input | 32 | Signed main voice sum, right |
| mem_addr | output | 16 | Byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| out_l | output | 16 | Signed final output, left |
| out_r | output | 16 | Signed final output, right |
| out_valid | output | 1 | One-cycle pulse for new outputs |

## Verification
A wrong offset or latched length shows up on `mem_addr` during the first read of the very next sample. A length fault that appears only at the wrap shows up after the full delay has elapsed, which is 512 samples for a 2048-byte area. A corrupted history entry does not show up at once. It reaches the outputs and the written-back bytes some time in the following seven samples, on the sample where that entry meets its coefficient. Errors in the mixing and saturation path show up in the sample they occur: on `out_l`/`out_r` at the `out_valid` pulse, and in the memory bytes a few cycles later.

// File: rtl/echo_fir_pkg.sv
package echo_fir_pkg;

  localparam int SMP_W      = 16;
  localparam int SEND_SHIFT = 7;
  localparam int GAIN_SHIFT = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LAST,
    ST_CALC,
    ST_MIX,
    ST_WRITE
  } seq_state_e;

  function automatic logic signed [SMP_W-1:0] clamp_smp(input logic signed [63:0] v);
    if (v > 64'sd32767)
      return 16'sh7FFF;
    else if (v < -64'sd32768)
      return 16'sh8000;
    else
      return v[SMP_W-1:0];
  endfunction

endpackage

// File: rtl/echo_frame_seq.sv
module echo_frame_seq
  import echo_fir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int DCODE_W    = 4,
  parameter int DUNIT_LOG2 = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic [PAGE_W-1:0]       start_page,
  input  logic [DCODE_W-1:0]      delay_code,
  input  logic                    wr_inhibit,
  input  logic [7:0]              mem_rdata,
  input  logic signed [SMP_W-1:0] wb_l,
  input  logic signed [SMP_W-1:0] wb_r,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [7:0]              mem_wdata,
  output logic signed [SMP_W-1:0] frame_l,
  output logic signed [SMP_W-1:0] frame_r,
  output logic                    calc_en,
  output logic                    mix_en
);

  localparam int FRAME_B = 2 * SMP_W / 8;
  localparam int CNT_W   = $clog2(FRAME_B);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_B - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] offset_q, offset_d;
  logic [ADDR_W-1:0] len_q, len_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              accept;
  logic              pend_q;
  logic [CNT_W-1:0]  pidx_q;
  logic [7:0]        frame_q [FRAME_B];
  logic [ADDR_W:0]   off_inc;

  // Offset / length arithmetic for the sample being accepted
  always_comb begin
    len_d    = (offset_q == '0) ? ADDR_W'({delay_code, {DUNIT_LOG2{1'b0}}}) : len_q;
    off_inc  = {1'b0, offset_q} + (ADDR_W+1)'(FRAME_B);
    offset_d = (off_inc >= {1'b0, len_d}) ? '0 : off_inc[ADDR_W-1:0];
    base_d   = ADDR_W'({start_page, 8'h00}) + offset_q;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (strobe) begin
          accept  = 1'b1;
          state_d = ST_READ;
          cnt_d   = '0;
        end
      end
      ST_READ: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_LAST;
      end
      ST_LAST: state_d = ST_CALC;
      ST_CALC: state_d = ST_MIX;
      ST_MIX: begin
        cnt_d   = '0;
        state_d = wr_inhibit ? ST_IDLE : ST_WRITE;
      end
      ST_WRITE: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      offset_q <= '0;
      len_q    <= '0;
      base_q   <= '0;
      pend_q   <= 1'b0;
      pidx_q   <= '0;
      for (int i = 0; i < FRAME_B; i++) frame_q[i] <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        offset_q <= offset_d;
        len_q    <= len_d;
        base_q   <= base_d;
      end
      pend_q <= mem_rd;
      pidx_q <= cnt_q;
      if (pend_q) frame_q[pidx_q] <= mem_rdata;
    end
  end

  // Memory port and stage enables
  always_comb begin
    mem_rd   = (state_q == ST_READ);
    mem_wr   = (state_q == ST_WRITE);
    mem_addr = base_q + ADDR_W'(cnt_q);
    calc_en  = (state_q == ST_CALC);
    mix_en   = (state_q == ST_MIX);
    case (cnt_q)
      2'd0:    mem_wdata = wb_l[7:0];
      2'd1:    mem_wdata = wb_l[15:8];
      2'd2:    mem_wdata = wb_r[7:0];
      default: mem_wdata = wb_r[15:8];
    endcase
  end

  assign frame_l = {frame_q[1], frame_q[0]};
  assign frame_r = {frame_q[3], frame_q[2]};

  // R1: one memory operation per cycle
  p_no_rd_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2: offset steps by one frame or wraps to zero
  p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && strobe) |=>
      (offset_q == $past(offset_q) + ADDR_W'(FRAME_B)) || (offset_q == '0));

endmodule

// File: rtl/echo_fir_bank.sv
module echo_fir_bank
  import echo_fir_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int TAPS   = 8,
  parameter int ACC_W  = 27
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      calc_en,
  input  logic signed [SMP_W-1:0]   in_l,
  input  logic signed [SMP_W-1:0]   in_r,
  input  logic [TAPS*COEF_W-1:0]    coef_bus,
  output logic signed [ACC_W-1:0]   fir_l,
  output logic signed [ACC_W-1:0]   fir_r
);

  localparam int HIST = TAPS - 1;

  logic signed [COEF_W-1:0] cf      [TAPS];
  logic signed [SMP_W-1:0]  smp_in  [2];
  logic signed [ACC_W-1:0]  fir_out [2];

  for (genvar k = 0; k < TAPS; k++) begin : g_coef
    assign cf[k] = coef_bus[k*COEF_W +: COEF_W];
  end

  assign smp_in[0] = in_l;
  assign smp_in[1] = in_r;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [SMP_W-1:0] hist_q [HIST];
    logic signed [ACC_W-1:0] acc_d, fir_q;

    // newest input on the top coefficient, oldest history on coefficient 0
    always_comb begin
      acc_d = ACC_W'(smp_in[ch]) * ACC_W'(cf[TAPS-1]);
      for (int j = 0; j < HIST; j++)
        acc_d = acc_d + ACC_W'(hist_q[j]) * ACC_W'(cf[HIST-1-j]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fir_q <= '0;
        for (int j = 0; j < HIST; j++) hist_q[j] <= '0;
      end else if (calc_en) begin
        fir_q     <= acc_d;
        hist_q[0] <= smp_in[ch];
        for (int j = 1; j < HIST; j++) hist_q[j] <= hist_q[j-1];
      end
    end

    assign fir_out[ch] = fir_q;
  end

  assign fir_l = fir_out[0];
  assign fir_r = fir_out[1];

endmodule

// File: rtl/echo_mixer.sv
module echo_mixer
  import echo_fir_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int SUM_W = 32,
  parameter int VOL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mix_en,
  input  logic signed [ACC_W-1:0] fir_l,
  input  logic signed [ACC_W-1:0] fir_r,
  input  logic signed [SUM_W-1:0] send_l,
  input  logic signed [SUM_W-1:0] send_r,
  input  logic signed [SUM_W-1:0] main_l,
  input  logic signed [SUM_W-1:0] main_r,
  input  logic signed [VOL_W-1:0] fb_gain,
  input  logic signed [VOL_W-1:0] mvol_l,
  input  logic signed [VOL_W-1:0] mvol_r,
  input  logic signed [VOL_W-1:0] evol_l,
  input  logic signed [VOL_W-1:0] evol_r,
  input  logic                    mute,
  output logic signed [SMP_W-1:0] wb_l,
  output logic signed [SMP_W-1:0] wb_r,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r,
  output logic                    out_valid
);

  logic signed [ACC_W-1:0] fir_a  [2];
  logic signed [SUM_W-1:0] send_a [2];
  logic signed [SUM_W-1:0] main_a [2];
  logic signed [VOL_W-1:0] mv_a   [2];
  logic signed [VOL_W-1:0] ev_a   [2];
  logic signed [SMP_W-1:0] wb_a   [2];
  logic signed [SMP_W-1:0] out_a  [2];
  logic                    valid_q;

  assign fir_a[0]  = fir_l;  assign fir_a[1]  = fir_r;
  assign send_a[0] = send_l; assign send_a[1] = send_r;
  assign main_a[0] = main_l; assign main_a[1] = main_r;
  assign mv_a[0]   = mvol_l; assign mv_a[1]   = mvol_r;
  assign ev_a[0]   = evol_l; assign ev_a[1]   = evol_r;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [63:0] f, s, m, g, mv, ev, wb_sum, out_sum;
    logic signed [SMP_W-1:0] wb_d, out_d, wb_q, out_q;

    always_comb begin
      f       = 64'(fir_a[ch]);
      s       = 64'(send_a[ch]);
      m       = 64'(main_a[ch]);
      g       = 64'(fb_gain);
      mv      = 64'(mv_a[ch]);
      ev      = 64'(ev_a[ch]);
      wb_sum  = (s >>> SEND_SHIFT) + ((f * g) >>> GAIN_SHIFT);
      out_sum = (m * mv + f * ev) >>> GAIN_SHIFT;
      wb_d    = clamp_smp(wb_sum);
      out_d   = mute ? '0 : clamp_smp(out_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wb_q  <= '0;
        out_q <= '0;
      end else if (mix_en) begin
        wb_q  <= wb_d;
        out_q <= out_d;
      end
    end

    assign wb_a[ch]  = wb_q;
    assign out_a[ch] = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= mix_en;
  end

  assign wb_l      = wb_a[0];
  assign wb_r      = wb_a[1];
  assign out_l     = out_a[0];
  assign out_r     = out_a[1];
  assign out_valid = valid_q;

  // R9: the valid strobe lasts one cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/echo_fir_unit.sv
module echo_fir_unit
  import echo_fir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int DCODE_W    = 4,
  parameter int DUNIT_LOG2 = 11,
  parameter int COEF_W     = 8,
  parameter int TAPS       = 8,
  parameter int SUM_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_strobe,
  input  logic [PAGE_W-1:0]        echo_page,
  input  logic [DCODE_W-1:0]       delay_code,
  input  logic [TAPS*COEF_W-1:0]   coef_bus,
  input  logic signed [COEF_W-1:0] fb_gain,
  input  logic signed [COEF_W-1:0] mvol_l,
  input  logic signed [COEF_W-1:0] mvol_r,
  input  logic signed [COEF_W-1:0] evol_l,
  input  logic signed [COEF_W-1:0] evol_r,
  input  logic                     wr_inhibit,
  input  logic                     mute,
  input  logic signed [SUM_W-1:0]  send_l,
  input  logic signed [SUM_W-1:0]  send_r,
  input  logic signed [SUM_W-1:0]  main_l,
  input  logic signed [SUM_W-1:0]  main_r,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic signed [SMP_W-1:0]  out_l,
  output logic signed [SMP_W-1:0]  out_r,
  output logic                     out_valid
);

  localparam int ACC_W = SMP_W + COEF_W + $clog2(TAPS);

  logic [1:0]              rst_pipe_q;
  logic                    rst_int_n;
  logic signed [SMP_W-1:0] frame_l, frame_r, wb_l, wb_r;
  logic signed [ACC_W-1:0] fir_l, fir_r;
  logic                    calc_en, mix_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  echo_frame_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DCODE_W(DCODE_W), .DUNIT_LOG2(DUNIT_LOG2)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .strobe(smp_strobe),
    .start_page(echo_page), .delay_code(delay_code), .wr_inhibit(wr_inhibit),
    .mem_rdata(mem_rdata), .wb_l(wb_l), .wb_r(wb_r),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .frame_l(frame_l), .frame_r(frame_r), .calc_en(calc_en), .mix_en(mix_en)
  );

  echo_fir_bank #(
    .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)
  ) u_fir (
    .clk(clk), .rst_n(rst_int_n), .calc_en(calc_en),
    .in_l(frame_l), .in_r(frame_r), .coef_bus(coef_bus),
    .fir_l(fir_l), .fir_r(fir_r)
  );

  echo_mixer #(
    .ACC_W(ACC_W), .SUM_W(SUM_W), .VOL_W(COEF_W)
  ) u_mix (
    .clk(clk), .rst_n(rst_int_n), .mix_en(mix_en),
    .fir_l(fir_l), .fir_r(fir_r), .send_l(send_l), .send_r(send_r),
    .main_l(main_l), .main_r(main_r), .fb_gain(fb_gain),
    .mvol_l(mvol_l), .mvol_r(mvol_r), .evol_l(evol_l), .evol_r(evol_r),
    .mute(mute), .wb_l(wb_l), .wb_r(wb_r),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
  );

  // R7: a muted sample presents zero on both outputs
  p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(mute)) |-> (out_l == '0 && out_r == '0));

  // R5: an inhibited sample goes straight back to idle without writing
  p_inhibit_nowr_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(wr_inhibit)) |-> !mem_wr);

endmodule

// File: tb/sim_echo_fir_unit.sv
module sim_echo_fir_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_strobe = 1'b0;
  logic [7:0]  echo_page = 8'h04;
  logic [3:0]  delay_code = 4'd2;
  logic [63:0] coef_bus = '0;
  logic signed [7:0]  fb_gain = '0, mvol_l = '0, mvol_r = '0, evol_l = '0, evol_r = '0;
  logic        wr_inhibit = 1'b0, mute = 1'b0;
  logic signed [31:0] send_l = '0, send_r = '0, main_l = '0, main_r = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic signed [15:0] out_l, out_r;
  logic        out_valid;

  always #2.5 clk = ~clk;

  echo_fir_unit u0 (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .echo_page(echo_page),
    .delay_code(delay_code), .coef_bus(coef_bus), .fb_gain(fb_gain),
    .mvol_l(mvol_l), .mvol_r(mvol_r), .evol_l(evol_l), .evol_r(evol_r),
    .wr_inhibit(wr_inhibit), .mute(mute), .send_l(send_l), .send_r(send_r),
    .main_l(main_l), .main_r(main_r), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
  );

  // byte memory, 4 KiB window (addresses alias on bits 11:0)
  logic [7:0]  mem [0:4095];
  logic        tb_we = 1'b0;
  logic [11:0] tb_waddr = '0;
  logic [7:0]  tb_wdata = '0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_waddr] <= tb_wdata;
    else if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int     off_m, len_m;
  longint h_l [7];
  longint h_r [7];
  int     cm  [8];

  localparam int NV = 8;
  localparam int V_SL [NV] = '{100000, 5000, 4000000, -3000, 64000, -80000, 12345, 0};
  localparam int V_SR [NV] = '{-70000, 300, -4000000, 9000, -64000, 80000, -777, 0};
  localparam int V_ML [NV] = '{200000, -40000, 1500, 2000000000, 300000, 250000, -99999, 16384};
  localparam int V_MR [NV] = '{-150000, 90000, -2500, -2000000000, -300000, 111111, 55555, -16384};
  localparam int V_IL [NV] = '{1000, -12000, 30000, 200, -5000, 7777, 32767, -1};
  localparam int V_IR [NV] = '{-2000, 7000, -30000, -300, 6000, -8888, -32768, 1};
  localparam int V_INH [NV] = '{0, 0, 0, 0, 1, 0, 1, 0};
  localparam int V_MUT [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic load_coefs();
    for (int k = 0; k < 8; k++) coef_bus[k*8 +: 8] = 8'(cm[k]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    off_m = 0;
    len_m = 0;
    for (int j = 0; j < 7; j++) begin h_l[j] = 0; h_r[j] = 0; end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = 12'(a); tb_wdata = 8'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic longint rd16(input int a);
    return longint'($signed({mem[12'(a + 1)], mem[12'(a)]}));
  endfunction

  // one sample: reference calculation, stimulus, then port checks
  task automatic run_sample(input bit preload, input int il, input int ir);
    int base, nxt;
    longint xl, xr, fl, fr, wl, wr, ol, orr, old_l, old_r;
    if (off_m == 0) len_m = int'(delay_code) * 2048;
    base = (int'(echo_page) * 256 + off_m) & 16'hFFFF;
    nxt = off_m + 4;
    off_m = (nxt >= len_m) ? 0 : nxt;
    if (preload) begin
      poke(base, il & 8'hFF); poke(base + 1, (il >> 8) & 8'hFF);
      poke(base + 2, ir & 8'hFF); poke(base + 3, (ir >> 8) & 8'hFF);
      @(negedge clk);
    end
    xl = rd16(base);
    xr = rd16(base + 2);
    old_l = xl; old_r = xr;
    fl = longint'(cm[7]) * xl;
    fr = longint'(cm[7]) * xr;
    for (int j = 0; j < 7; j++) begin
      fl += longint'(cm[6-j]) * h_l[j];
      fr += longint'(cm[6-j]) * h_r[j];
    end
    for (int j = 6; j > 0; j--) begin h_l[j] = h_l[j-1]; h_r[j] = h_r[j-1]; end
    h_l[0] = xl; h_r[0] = xr;
    wl = sat16((longint'(send_l) >>> 7) + ((fl * longint'(fb_gain)) >>> 14));
    wr = sat16((longint'(send_r) >>> 7) + ((fr * longint'(fb_gain)) >>> 14));
    ol = mute ? 0 : sat16((longint'(main_l) * longint'(mvol_l) + fl * longint'(evol_l)) >>> 14);
    orr = mute ? 0 : sat16((longint'(main_r) * longint'(mvol_r) + fr * longint'(evol_r)) >>> 14);
    if (wr_inhibit) begin wl = old_l; wr = old_r; end

    @(negedge clk); smp_strobe = 1'b1;
    @(negedge clk); smp_strobe = 1'b0;
    while (!mem_rd) @(negedge clk);
    check("R1 R2 first read address", longint'(mem_addr), longint'(base));
    while (!out_valid) @(negedge clk);
    check("R6 R3 R7 R8 out_l", longint'(out_l), ol);
    check("R6 R3 R7 R8 out_r", longint'(out_r), orr);
    @(negedge clk);
    check("R9 out_valid single cycle", longint'(out_valid), 0);
    repeat (5) @(negedge clk);
    check("R4 R5 R1 frame left in memory", rd16(base), wl);
    check("R4 R5 R1 frame right in memory", rd16(base + 2), wr);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state at the ports
    check("R9 reset out_l", longint'(out_l), 0);
    check("R9 reset out_r", longint'(out_r), 0);
    check("R9 reset out_valid", longint'(out_valid), 0);
    check("R1 reset mem_rd", longint'(mem_rd), 0);
    check("R1 reset mem_wr", longint'(mem_wr), 0);

    // R3: cleared history, only the newest-previous tap active
    cm = '{0, 0, 0, 0, 0, 0, 64, 0};
    load_coefs();
    evol_l = 8'sd127; evol_r = 8'sd127; fb_gain = 8'sd0;
    run_sample(1'b1, 20000, -20000);
    run_sample(1'b1, 1000, 1000);

    // table walk: R3 R4 R5 R6 R7 R8 with full coefficient set
    do_reset();
    cm = '{40, -3, 5, -128, 9, -11, 13, 100};
    load_coefs();
    fb_gain = 8'sd70; mvol_l = 8'sd100; mvol_r = -8'sd90;
    evol_l = 8'sd50; evol_r = -8'sd60;
    echo_page = 8'h04; delay_code = 4'd2;
    for (int v = 0; v < NV; v++) begin
      send_l = V_SL[v]; send_r = V_SR[v];
      main_l = V_ML[v]; main_r = V_MR[v];
      wr_inhibit = V_INH[v][0]; mute = V_MUT[v][0];
      run_sample(1'b1, V_IL[v], V_IR[v]);
    end
    wr_inhibit = 1'b0; mute = 1'b0;

    // R8: strong negative feedback saturates write-back low
    send_l = -32'sd8000000; send_r = 32'sd8000000;
    run_sample(1'b1, -32768, 32767);

    // R2: length latched only at offset zero, then zero length pins the frame
    do_reset();
    echo_page = 8'h08; delay_code = 4'd1;
    send_l = 32'sd3000; send_r = -32'sd3000;
    run_sample(1'b0, 0, 0);
    delay_code = 4'd0;
    for (int i = 1; i < 514; i++) run_sample(1'b0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule